// File: doc/BRIEF.md
# Receive Packet Buffer Pool

This block takes a framed byte stream and turns it into whole packets held in a small pool of byte-wide RAM buffers. A client then receives those packets one at a time through a random-access read port instead of a stream. Each ingress byte arrives with a valid strobe. A start flag marks the first byte of a packet and an end flag marks the last byte, and a 2-bit source tag is taken from the first byte. The block writes each packet into a buffer that is currently free. Once the last byte is stored, the buffer's index joins an arrival-order queue.

When the client is idle, the block takes the oldest queued buffer and pulses `cl_go` for one cycle. It presents the packet's last-byte index and its source tag, which stay unchanged until the client answers with a one-cycle `cl_done` pulse. That pulse hands the buffer back to the free pool. While the client works on one buffer, ingress keeps filling the other buffers.

There is no backpressure toward ingress. A packet that starts when every buffer is taken is thrown away whole, and so is a packet that grows past the buffer capacity. Each discarded packet advances a wrapping drop counter.

Top module: `rx_pkt_pool`

## Requirements
- R1: While a packet is presented, the byte at index i of that packet appears on `cl_rd_data` exactly RD_LAT clock edges after `cl_rd_addr` = i was driven, with RD_LAT = 2 by default.
- R2: `cl_go` is high for exactly one cycle per delivered packet. When the client is idle and no earlier packet is waiting, `cl_go` is high in the second cycle after the cycle that carried the packet's last byte.
- R3: During the `cl_go` cycle, `cl_len` equals the number of packet bytes minus one, and `cl_tag` equals the tag sampled with the start byte. Both hold their values until the cycle after `cl_done`.
- R4: The contents of a presented buffer do not change between its `cl_go` and the client's `cl_done`, even while other packets arrive.
- R5: A `cl_done` pulse releases the presented buffer. If another packet is waiting, its `cl_go` appears two cycles after the `cl_done` cycle.
- R6: Completed packets are presented in the order their last bytes arrived.
- R7: Ingress stores new packets while the client holds a buffer, up to NUM_BUF (default 4) buffers in use in total, counting the buffer being filled, the queued buffers and the held buffer.
- R8: A packet whose start byte arrives while all NUM_BUF buffers are in use is discarded whole, and `drop_cnt` increases by exactly one.
- R9: A packet longer than 2^ADDR_W = 2048 bytes is discarded, its buffer goes back to the pool, and `drop_cnt` increases by one. A packet of exactly 2048 bytes is delivered with `cl_len` = 2047.
- R10: A `cl_done` pulse while no packet is presented has no effect. No buffer is freed and no `cl_go` follows from it.
- R11: Valid bytes outside a packet (no start flag while idle) are not stored and produce no `cl_go`.
- R12: After reset, `cl_go` is low, `drop_cnt` is zero and all buffers are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Ingress byte strobe |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_eop | input | 1 | Marks the last byte of a packet |
| in_data | input | 8 | Ingress byte |
| in_tag | input | 2 | Source tag, sampled with the first byte |
| cl_go | output | 1 | One-cycle pulse: a packet is presented |
| cl_len | output | 11 | Index of the last byte of the presented packet |
| cl_tag | output | 2 | Source tag of the presented packet |
| cl_rd_addr | input | 11 | Client read index |
| cl_rd_data | output | 8 | Byte read from the presented buffer, RD_LAT cycles late |
| cl_done | input | 1 | One-cycle pulse from the client: buffer released |
| drop_cnt | output | 16 | Wrapping count of discarded packets |

## Verification
The embedded assertions assume that ingress framing is well formed: no start flag arrives while a packet is still being filled. They also assume that `cl_done` releases only a buffer that is actually presented. The stimulus tasks always close a packet with an end flag before the next start flag, and they send stray bytes only between packets. The client model raises `cl_done` only after it has seen `cl_go`, apart from deliberate `cl_done` pulses injected while it is idle. The bench predicts `cl_go`, length, tag, read data and drop count with a behavioural model. The stimulus covers a slow client, a pool held full, oversize packets and the exact-capacity packet.

// File: rtl/rxp_pkg.sv
// Shared types for the receive packet buffer pool.
package rxp_pkg;
    // Ingress framing state: waiting for a start byte, filling a buffer, or skipping a dropped packet.
    typedef enum logic [1:0] {
        ING_IDLE = 2'd0,
        ING_FILL = 2'd1,
        ING_SKIP = 2'd2
    } ing_state_t;
endpackage

// File: rtl/rxp_bank.sv
// One packet buffer: byte-wide RAM with a synchronous write port and a registered read.
// Assumes the write and read never target the same entry in the same cycle while the data matters.
module rxp_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an ingress byte and register the client's read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/rxp_order_q.sv
// Arrival-order queue of completed buffer descriptors.
// Assumes pop is only requested while not_empty is high.
module rxp_order_q #(
    parameter int ENTRY_W = 16,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head,
    output logic               not_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENTRY_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]   count_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    // Hold the queued descriptors.
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_data;
    end

    assign head      = slot_q[rd_ptr_q];
    assign not_empty = (count_q != '0);

    // R6: the queue never takes more descriptors than it has room for.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count_q < CNT_W'(DEPTH)));
    // R6: nothing is removed from an empty queue.
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
endmodule

// File: rtl/rxp_ingress.sv
// Ingress framer: owns the free-buffer pool, writes packet bytes into a claimed buffer,
// posts completed packets and counts discarded ones.
// Assumes well-formed framing: every started packet ends with an end byte before the next start byte.
module rxp_ingress
    import rxp_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int TAG_W   = 2,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [TAG_W-1:0]   in_tag,
    input  logic [NUM_BUF-1:0] release_vec,
    output logic               wr_en,
    output logic [$clog2(NUM_BUF)-1:0] wr_buf,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               done_push,
    output logic [$clog2(NUM_BUF)-1:0] done_idx,
    output logic [ADDR_W-1:0]  done_len,
    output logic [TAG_W-1:0]   done_tag,
    output logic [CNT_W-1:0]   drop_cnt
);
    localparam int IDX_W = $clog2(NUM_BUF);
    localparam logic [ADDR_W:0] CAP = {1'b1, {ADDR_W{1'b0}}};

    ing_state_t         st_q, st_d;
    logic [ADDR_W:0]    cnt_q, cnt_d;
    logic [IDX_W-1:0]   buf_q, buf_d;
    logic [TAG_W-1:0]   tag_q, tag_d;
    logic [NUM_BUF-1:0] free_q;
    logic [IDX_W-1:0]   pick;
    logic               have_free, claim, ovf_rel, drop_inc;

    // Lowest-numbered free buffer.
    always_comb begin
        pick = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (free_q[i]) pick = IDX_W'(i);
        end
    end
    assign have_free = |free_q;
    assign wr_data   = in_data;

    // Framing decisions for the current ingress byte.
    always_comb begin
        st_d = st_q;  cnt_d = cnt_q;  buf_d = buf_q;  tag_d = tag_q;
        claim = 1'b0; ovf_rel = 1'b0; drop_inc = 1'b0;
        wr_en = 1'b0; wr_buf = buf_q; wr_addr = cnt_q[ADDR_W-1:0];
        done_push = 1'b0; done_idx = buf_q; done_len = cnt_q[ADDR_W-1:0]; done_tag = tag_q;
        unique case (st_q)
            ING_IDLE: begin
                if (in_valid && in_sop) begin
                    if (have_free) begin
                        claim = 1'b1;  wr_en = 1'b1;  wr_buf = pick;  wr_addr = '0;
                        buf_d = pick;  tag_d = in_tag;  cnt_d = (ADDR_W+1)'(1);
                        if (in_eop) begin
                            done_push = 1'b1;  done_idx = pick;  done_len = '0;  done_tag = in_tag;
                        end else begin
                            st_d = ING_FILL;
                        end
                    end else begin
                        drop_inc = 1'b1;
                        st_d = in_eop ? ING_IDLE : ING_SKIP;
                    end
                end
            end
            ING_FILL: begin
                if (in_valid) begin
                    if (cnt_q == CAP) begin
                        ovf_rel = 1'b1;  drop_inc = 1'b1;
                        st_d = in_eop ? ING_IDLE : ING_SKIP;
                    end else begin
                        wr_en = 1'b1;
                        cnt_d = cnt_q + 1'b1;
                        if (in_eop) begin
                            done_push = 1'b1;
                            st_d = ING_IDLE;
                        end
                    end
                end
            end
            ING_SKIP: begin
                if (in_valid && in_eop) st_d = ING_IDLE;
            end
            default: st_d = ING_IDLE;
        endcase
    end

    // Framing state, write cursor and the tag of the packet being filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ING_IDLE;  cnt_q <= '0;  buf_q <= '0;  tag_q <= '0;
        end else begin
            st_q <= st_d;  cnt_q <= cnt_d;  buf_q <= buf_d;  tag_q <= tag_d;
        end
    end

    // Free pool: buffers return from the client or from an overflow, and leave when claimed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q <= '1;
        end else begin
            free_q <= (free_q | release_vec | (ovf_rel ? (NUM_BUF'(1) << buf_q) : '0))
                      & ~(claim ? (NUM_BUF'(1) << pick) : '0);
        end
    end

    // Discard counter, one step per dropped packet.
    always_ff @(posedge clk) begin
        if (!rst_n)        drop_cnt <= '0;
        else if (drop_inc) drop_cnt <= drop_cnt + 1'b1;
    end

    // R8: the drop counter only ever advances by one per cycle.
    p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));
    // R5: the client only returns buffers that are not already free.
    p_release_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (release_vec & free_q) == '0);
    // R9: the write cursor never passes the buffer capacity.
    p_cursor_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);
    // R11: input assumption - no start byte while a packet is still being filled.
    p_framing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |-> (st_q != ING_FILL));
endmodule

// File: rtl/rxp_client.sv
// Client handshake: takes the oldest completed buffer when idle, pulses go, holds length and tag,
// and returns the buffer on done. A done with nothing presented is ignored.
module rxp_client #(
    parameter int NUM_BUF = 4,
    parameter int ADDR_W  = 11,
    parameter int TAG_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_valid,
    input  logic [$clog2(NUM_BUF)-1:0] q_idx,
    input  logic [ADDR_W-1:0]  q_len,
    input  logic [TAG_W-1:0]   q_tag,
    output logic               q_pop,
    input  logic               done,
    output logic               go,
    output logic [ADDR_W-1:0]  len,
    output logic [TAG_W-1:0]   tag,
    output logic [$clog2(NUM_BUF)-1:0] cur,
    output logic               busy,
    output logic [NUM_BUF-1:0] release_vec
);
    assign q_pop       = !busy && q_valid;
    assign release_vec = (busy && done) ? (NUM_BUF'(1) << cur) : '0;

    // Present the next buffer or release the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;  go <= 1'b0;  len <= '0;  tag <= '0;  cur <= '0;
        end else begin
            go <= q_pop;
            if (q_pop) begin
                busy <= 1'b1;  cur <= q_idx;  len <= q_len;  tag <= q_tag;
            end else if (busy && done) begin
                busy <= 1'b0;
            end
        end
    end

    // R2: go never lasts longer than one cycle.
    p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);
    // R3: length, tag and buffer stay put while the packet is presented.
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !go) |-> ($stable(len) && $stable(tag) && $stable(cur)));
    // R10: a done with nothing presented does not start a presentation.
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && !q_valid) |=> !busy);
endmodule

// File: rtl/rx_pkt_pool.sv
// Top of the receive packet buffer pool: ingress framer, per-buffer RAM banks,
// arrival-order queue and client handshake, with a fixed-latency read path.
// Assumes RD_LAT >= 1 and NUM_BUF >= 2.
module rx_pkt_pool #(
    parameter int NUM_BUF = 4,
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int TAG_W   = 2,
    parameter int RD_LAT  = 2,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              cl_go,
    output logic [ADDR_W-1:0] cl_len,
    output logic [TAG_W-1:0]  cl_tag,
    input  logic [ADDR_W-1:0] cl_rd_addr,
    output logic [DATA_W-1:0] cl_rd_data,
    input  logic              cl_done,
    output logic [CNT_W-1:0]  drop_cnt
);
    localparam int IDX_W   = $clog2(NUM_BUF);
    localparam int ENTRY_W = IDX_W + ADDR_W + TAG_W;

    logic               wr_en, push, pop, q_valid, busy;
    logic [IDX_W-1:0]   wr_buf, push_idx, cur;
    logic [ADDR_W-1:0]  wr_addr, push_len;
    logic [DATA_W-1:0]  wr_data;
    logic [TAG_W-1:0]   push_tag;
    logic [ENTRY_W-1:0] head;
    logic [NUM_BUF-1:0] release_vec;
    logic [DATA_W-1:0]  bank_q [NUM_BUF];
    logic [DATA_W-1:0]  sel_q;

    rxp_ingress #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) ing_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_tag(in_tag), .release_vec(release_vec),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr), .wr_data(wr_data),
        .done_push(push), .done_idx(push_idx), .done_len(push_len), .done_tag(push_tag),
        .drop_cnt(drop_cnt)
    );

    rxp_order_q #(.ENTRY_W(ENTRY_W), .DEPTH(NUM_BUF)) ord_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data({push_idx, push_len, push_tag}),
        .pop(pop), .head(head), .not_empty(q_valid)
    );

    rxp_client #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) cli_i (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid),
        .q_idx(head[ENTRY_W-1 -: IDX_W]), .q_len(head[TAG_W +: ADDR_W]), .q_tag(head[TAG_W-1:0]),
        .q_pop(pop), .done(cl_done), .go(cl_go), .len(cl_len), .tag(cl_tag),
        .cur(cur), .busy(busy), .release_vec(release_vec)
    );

    // One RAM bank per buffer; ingress writes the bank it owns, all banks follow the client address.
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank
        rxp_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
            .clk(clk), .wr_en(wr_en && (wr_buf == IDX_W'(b))), .wr_addr(wr_addr),
            .wr_data(wr_data), .rd_addr(cl_rd_addr), .rd_data(bank_q[b])
        );
    end

    assign sel_q = bank_q[cur];

    // Extra read stages so the total read latency equals RD_LAT.
    if (RD_LAT == 1) begin : g_lat1
        assign cl_rd_data = sel_q;
    end else begin : g_latn
        logic [DATA_W-1:0] stage_q [RD_LAT-1];
        // Delay line for the selected byte.
        always_ff @(posedge clk) begin
            stage_q[0] <= sel_q;
            for (int k = 1; k < RD_LAT - 1; k++) stage_q[k] <= stage_q[k-1];
        end
        assign cl_rd_data = stage_q[RD_LAT-2];
    end

    // R4: ingress never writes into the buffer the client is holding.
    p_no_write_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |-> (wr_buf != cur));
endmodule

// File: tb/rx_pkt_pool_tb_top.sv
module rx_pkt_pool_tb_top;
    localparam int NB = 4;
    localparam int RL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    logic [1:0] in_tag = '0;
    logic cl_go;
    logic [10:0] cl_len;
    logic [1:0] cl_tag;
    logic [10:0] cl_rd_addr = '0;
    logic [7:0] cl_rd_data;
    logic cl_done = 1'b0;
    logic [15:0] drop_cnt;

    always #4 clk = ~clk;

    rx_pkt_pool dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_tag(in_tag), .cl_go(cl_go), .cl_len(cl_len), .cl_tag(cl_tag),
        .cl_rd_addr(cl_rd_addr), .cl_rd_data(cl_rd_data), .cl_done(cl_done), .drop_cnt(drop_cnt)
    );

    int vectors = 0, fails = 0, cyc = 0;
    string scen = "R12";
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (scenario %s): actual %0d expected %0d", req, scen, act, exp);
        end
    endtask

    // Reference model state.
    int m_mode = 0, m_cnt = 0, m_tag = 0, m_drop = 0, m_seq = 0;
    int stg[64];
    int pmem[8][64];
    int plen[8], ptag[8];
    int pend[$];
    bit m_busy = 0, m_go = 0;
    int m_slot = 0;
    int rpipe[RL];

    function automatic int pbyte(input int seed, input int i);
        return (seed * 13 + i * 7 + 5) & 255;
    endfunction

    // Cycle model: client step first (pre-edge queue), then ingress step.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_drop = 0; m_busy = 0; m_go = 0;
            pend.delete();
            for (int k = 0; k < RL; k++) rpipe[k] = -1;
        end else begin
            int used, e;
            used = (m_mode == 1 ? 1 : 0) + pend.size() + (m_busy ? 1 : 0);
            e = -1;
            if (m_busy && cl_rd_addr <= 11'(plen[m_slot]) && cl_rd_addr < 64)
                e = pmem[m_slot][cl_rd_addr];
            for (int k = RL - 1; k > 0; k--) rpipe[k] = rpipe[k-1];
            rpipe[0] = e;
            m_go = 0;
            if (m_busy && cl_done) m_busy = 0;
            else if (!m_busy && pend.size() > 0) begin
                m_slot = pend.pop_front(); m_busy = 1; m_go = 1;
            end
            if (in_valid) begin
                bit fin;
                fin = 0;
                if (m_mode == 0) begin
                    if (in_sop) begin
                        if (used < NB) begin
                            stg[0] = in_data; m_tag = in_tag; m_cnt = 1;
                            if (in_eop) fin = 1; else m_mode = 1;
                        end else begin
                            m_drop++; m_mode = in_eop ? 0 : 2;
                        end
                    end
                end else if (m_mode == 1) begin
                    if (m_cnt == 2048) begin
                        m_drop++; m_mode = in_eop ? 0 : 2;
                    end else begin
                        if (m_cnt < 64) stg[m_cnt] = in_data;
                        m_cnt++;
                        if (in_eop) begin fin = 1; m_mode = 0; end
                    end
                end else if (in_eop) m_mode = 0;
                if (fin) begin
                    int s;
                    s = m_seq % 8; m_seq++;
                    for (int k = 0; k < 64; k++) pmem[s][k] = (k < m_cnt) ? stg[k] : -1;
                    plen[s] = m_cnt - 1; ptag[s] = m_tag;
                    pend.push_back(s);
                end
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cl_go == m_go, "R2", int'(cl_go), int'(m_go));
            chk(drop_cnt == 16'(m_drop), "R8", int'(drop_cnt), m_drop);
            if (m_go) begin
                chk(cl_len == 11'(plen[m_slot]), "R3", int'(cl_len), plen[m_slot]);
                chk(cl_tag == 2'(ptag[m_slot]), "R3", int'(cl_tag), ptag[m_slot]);
            end
            if (rpipe[RL-1] >= 0)
                chk(cl_rd_data == 8'(rpipe[RL-1]), "R1", int'(cl_rd_data), rpipe[RL-1]);
        end
    end

    // Behavioural client: sweep the packet, wait, then release.
    bit c_act = 0, auto_en = 1, spur_req = 0;
    int c_len = 0, c_a = 0, c_wait = 0, hold_cycles = 2;
    int go_seen = 0;
    always @(negedge clk) begin
        cl_done = 1'b0;
        if (spur_req && !c_act) begin cl_done = 1'b1; spur_req = 0; end
        if (!c_act) begin
            if (cl_go && rst_n) begin
                c_act = 1; c_len = int'(cl_len); c_a = 0; c_wait = hold_cycles; go_seen++;
            end
        end else begin
            if (c_a < c_len) c_a++;
            else if (c_wait > 0) c_wait--;
            else if (auto_en) begin cl_done = 1'b1; c_act = 0; end
        end
        cl_rd_addr = 11'(c_a);
    end

    task automatic send_pkt(input int n, input int tag, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1; in_sop = (i == 0); in_eop = (i == n - 1);
            in_data = 8'(pbyte(seed, i)); in_tag = 2'(tag);
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!c_act && !m_busy && pend.size() == 0 && m_mode == 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog (scenario %s): actual %0d expected %0d", scen, cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int base, g0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        scen = "R12";
        chk(cl_go == 1'b0, "R12", int'(cl_go), 0);
        chk(drop_cnt == 16'd0, "R12", int'(drop_cnt), 0);

        scen = "R1";
        send_pkt(1, 1, 3);
        send_pkt(5, 2, 4);
        send_pkt(64, 3, 9);
        wait_idle();

        scen = "R2";
        @(negedge clk);
        in_valid = 1; in_sop = 1; in_eop = 1; in_data = 8'h5a; in_tag = 2'd2;
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
        chk(cl_go == 1'b0, "R2", int'(cl_go), 0);
        @(negedge clk);
        chk(cl_go == 1'b1, "R2", int'(cl_go), 1);
        chk(cl_len == 11'd0, "R3", int'(cl_len), 0);
        wait_idle();

        scen = "R11";
        g0 = go_seen;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1; in_sop = 0; in_eop = (i == 5); in_data = 8'(i);
        end
        @(negedge clk);
        in_valid = 0; in_eop = 0;
        repeat (6) @(negedge clk);
        chk(go_seen == g0, "R11", go_seen, g0);
        send_pkt(7, 0, 21);
        wait_idle();

        scen = "R6";
        hold_cycles = 30;
        send_pkt(10, 1, 30);
        send_pkt(3, 2, 31);
        send_pkt(12, 3, 32);
        scen = "R7";
        send_pkt(8, 0, 33);
        wait_idle();
        hold_cycles = 2;

        scen = "R8";
        base = int'(drop_cnt);
        auto_en = 0;
        send_pkt(4, 0, 40);
        send_pkt(4, 1, 41);
        send_pkt(4, 2, 42);
        send_pkt(4, 3, 43);
        send_pkt(9, 1, 44);
        send_pkt(1, 2, 45);
        repeat (4) @(negedge clk);
        chk(int'(drop_cnt) == base + 2, "R8", int'(drop_cnt), base + 2);
        scen = "R4";
        repeat (20) @(negedge clk);
        scen = "R5";
        auto_en = 1;
        wait_idle();

        scen = "R10";
        g0 = go_seen;
        spur_req = 1;
        repeat (4) @(negedge clk);
        chk(go_seen == g0, "R10", go_seen, g0);
        base = int'(drop_cnt);
        auto_en = 0;
        send_pkt(3, 0, 50);
        send_pkt(3, 1, 51);
        send_pkt(3, 2, 52);
        send_pkt(3, 3, 53);
        send_pkt(3, 0, 54);
        repeat (4) @(negedge clk);
        chk(int'(drop_cnt) == base + 1, "R10", int'(drop_cnt), base + 1);
        auto_en = 1;
        wait_idle();

        scen = "R9";
        base = int'(drop_cnt);
        send_pkt(2049, 1, 60);
        repeat (4) @(negedge clk);
        chk(int'(drop_cnt) == base + 1, "R9", int'(drop_cnt), base + 1);
        send_pkt(2048, 2, 61);
        wait_idle();
        send_pkt(4, 3, 62);
        wait_idle();
        chk(int'(drop_cnt) == base + 1, "R9", int'(drop_cnt), base + 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule